// File: doc/BRIEF.md
# Dual-Half Iterative Shift-Add Multiplier

This block multiplies two 32-bit operands over a fixed number of clock cycles using only adders and shifters. One shared loop of 32 iterations builds two products at once. The low 32 bits of the product build up in one accumulator: it shifts left each pass and takes the multiplicand when the top bit of a left-shifting copy of the multiplier is set. The unsigned upper 32 bits build up in a second accumulator: it takes the multiplicand when the bottom bit of a right-shifting copy of the multiplier is set, then shifts right and keeps the adder carry in its top bit.

After the loop, a 2-bit mode selects the answer. When one or both operands are signed, the unsigned upper half is adjusted by one or two extra subtraction cycles. Those subtractions use an unshifted copy of the multiplier that is kept for this purpose.

Requests enter through a valid/ready handshake. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until the result has been delivered, so a busy block applies back-pressure and a held request waits. The result has no back-pressure: `done` pulses for one cycle, and `result` carries the answer only in that cycle.

Top module: `shiftadd_mul`

## Requirements
- R1: `in_ready` is high only while the block is idle. It falls on the edge that accepts a request and stays low through the cycle in which `done` is high.
- R2: Take the accepting edge as edge 0. `done` is high in the cycle that follows edge 32 for the low and unsigned-high modes, edge 33 for signed×unsigned, and edge 34 for signed×signed.
- R3: With mode 2'b00, `result` equals the low 32 bits of the product, and the result is the same for any sign of either operand.
- R4: With mode 2'b01, `result` equals bits 63:32 of the product of both operands taken as unsigned.
- R5: With mode 2'b10, `result` equals bits 63:32 of the product of a signed multiplicand and an unsigned multiplier.
- R6: With mode 2'b11, `result` equals bits 63:32 of the product of both operands taken as signed.
- R7: `done` is never high on two consecutive cycles. `result` is zero whenever `done` is low.
- R8: After synchronous reset, `in_ready` is 1, `done` is 0 and `result` is 0.
- R9: `in_valid` asserted while the block is busy starts no new operation and does not alter the running one. Each accepted request yields exactly one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present on the operand and mode inputs |
| in_ready | output | 1 | Block idle and able to take a request |
| in_mcand | input | 32 | Multiplicand |
| in_mplr | input | 32 | Multiplier |
| in_mode | input | 2 | 00 low half, 01 high unsigned, 10 high signed×unsigned, 11 high signed×signed |
| done | output | 1 | One-cycle pulse marking a valid result |
| result | output | 32 | Selected product half, valid while done is high |

## Verification
On every cycle, the bound checker tracks the handshake, the single-cycle `done` pulse and the latency for each mode, which it measures with a counter. Whenever `done` is high, it also compares `result` against a wide product formed from the operands it captured at acceptance. Only the bench scenarios show that specific operand sets give the right answers. These include the corner values 0, 1, −1, the largest positive and the most negative number in every mode pairing, and random operands. The bench also shows that requests presented while busy are dropped, with the accepted count matching the delivered count.

// File: rtl/shiftadd_mul_pkg.sv
package shiftadd_mul_pkg;
  typedef enum logic [1:0] {
    MODE_LO  = 2'b00,
    MODE_HUU = 2'b01,
    MODE_HSU = 2'b10,
    MODE_HSS = 2'b11
  } mul_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOP,
    ST_FIX_SU,
    ST_FIX_SS,
    ST_DONE
  } mul_state_e;
endpackage

// File: rtl/sam_ctrl.sv
module sam_ctrl
  import shiftadd_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      accept,
  input  mul_mode_e mode_in,
  output mul_mode_e mode_q,
  output logic      idle,
  output logic      step,
  output logic      fix_su,
  output logic      fix_ss,
  output logic      done
);
  localparam int CNT_W = $clog2(WIDTH);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  mul_state_e       state_q;
  logic [CNT_W-1:0] iter_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      iter_q  <= '0;
      mode_q  <= MODE_LO;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_LOOP;
            iter_q  <= '0;
            mode_q  <= mode_in;
          end
        end
        ST_LOOP: begin
          iter_q <= iter_q + 1'b1;
          if (iter_q == LAST) begin
            if (mode_q == MODE_HSU || mode_q == MODE_HSS) state_q <= ST_FIX_SU;
            else                                          state_q <= ST_DONE;
          end
        end
        ST_FIX_SU: state_q <= (mode_q == MODE_HSS) ? ST_FIX_SS : ST_DONE;
        ST_FIX_SS: state_q <= ST_DONE;
        ST_DONE:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle   = (state_q == ST_IDLE);
  assign step   = (state_q == ST_LOOP);
  assign fix_su = (state_q == ST_FIX_SU);
  assign fix_ss = (state_q == ST_FIX_SS);
  assign done   = (state_q == ST_DONE);
endmodule

// File: rtl/sam_sign_fix.sv
module sam_sign_fix #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] hi_in,
  input  logic [WIDTH-1:0] mcand,
  input  logic [WIDTH-1:0] mplr_keep,
  input  logic             sel_su,
  input  logic             sel_ss,
  output logic [WIDTH-1:0] hi_out
);
  logic [WIDTH-1:0] sub;

  always_comb begin
    sub = '0;
    if (sel_su && mcand[WIDTH-1])         sub = mplr_keep;
    else if (sel_ss && mplr_keep[WIDTH-1]) sub = mcand;
    hi_out = hi_in - sub;
  end
endmodule

// File: rtl/sam_datapath.sv
module sam_datapath #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic             fix_su,
  input  logic             fix_ss,
  input  logic [WIDTH-1:0] op_mcand,
  input  logic [WIDTH-1:0] op_mplr,
  output logic [WIDTH-1:0] lo_acc,
  output logic [WIDTH-1:0] hi_acc
);
  logic [WIDTH-1:0] mcand_q, keep_q, mplr_l_q, mplr_r_q;
  logic [WIDTH-1:0] lo_next, hi_next, hi_fixed;
  logic [WIDTH:0]   hi_sum;

  // low half: shift first, then add when the top of the left-moving copy is set
  assign lo_next = {lo_acc[WIDTH-2:0], 1'b0} + (mplr_l_q[WIDTH-1] ? mcand_q : '0);

  // high half: add when the bottom of the right-moving copy is set, carry enters top bit
  assign hi_sum  = {1'b0, hi_acc} + {1'b0, (mplr_r_q[0] ? mcand_q : '0)};
  assign hi_next = hi_sum[WIDTH:1];

  sam_sign_fix #(.WIDTH(WIDTH)) fix_i (
    .hi_in    (hi_acc),
    .mcand    (mcand_q),
    .mplr_keep(keep_q),
    .sel_su   (fix_su),
    .sel_ss   (fix_ss),
    .hi_out   (hi_fixed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q  <= '0;
      keep_q   <= '0;
      mplr_l_q <= '0;
      mplr_r_q <= '0;
      lo_acc   <= '0;
      hi_acc   <= '0;
    end else if (load) begin
      mcand_q  <= op_mcand;
      keep_q   <= op_mplr;
      mplr_l_q <= op_mplr;
      mplr_r_q <= op_mplr;
      lo_acc   <= '0;
      hi_acc   <= '0;
    end else if (step) begin
      lo_acc   <= lo_next;
      hi_acc   <= hi_next;
      mplr_l_q <= {mplr_l_q[WIDTH-2:0], 1'b0};
      mplr_r_q <= {1'b0, mplr_r_q[WIDTH-1:1]};
    end else if (fix_su || fix_ss) begin
      hi_acc   <= hi_fixed;
    end
  end
endmodule

// File: rtl/shiftadd_mul.sv
module shiftadd_mul
  import shiftadd_mul_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_mcand,
  input  logic [WIDTH-1:0] in_mplr,
  input  logic [1:0]       in_mode,
  output logic             done,
  output logic [WIDTH-1:0] result
);
  logic             accept, step, fix_su, fix_ss;
  mul_mode_e        mode_q;
  logic [WIDTH-1:0] lo_acc, hi_acc;

  assign accept = in_valid && in_ready;

  sam_ctrl #(.WIDTH(WIDTH)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .mode_in(mul_mode_e'(in_mode)),
    .mode_q (mode_q),
    .idle   (in_ready),
    .step   (step),
    .fix_su (fix_su),
    .fix_ss (fix_ss),
    .done   (done)
  );

  sam_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .step    (step),
    .fix_su  (fix_su),
    .fix_ss  (fix_ss),
    .op_mcand(in_mcand),
    .op_mplr (in_mplr),
    .lo_acc  (lo_acc),
    .hi_acc  (hi_acc)
  );

  assign result = !done ? '0 : (mode_q == MODE_LO) ? lo_acc : hi_acc;
endmodule

// File: rtl/shiftadd_mul_chk.sv
module shiftadd_mul_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_mcand,
  input logic [WIDTH-1:0] in_mplr,
  input logic [1:0]       in_mode,
  input logic             done,
  input logic [WIDTH-1:0] result
);
  localparam int W2    = 2 * WIDTH;
  localparam int LAT_W = $clog2(WIDTH + 4) + 1;

  logic             acc;
  logic [WIDTH-1:0] a_q, b_q;
  logic [1:0]       m_q;
  logic             track_q, was_rst_q;
  logic [LAT_W-1:0] lat_q, lat_exp;
  logic [W2-1:0]    p_uu, p_su, p_ss;

  assign acc  = in_valid && in_ready;
  assign p_uu = {{WIDTH{1'b0}}, a_q} * {{WIDTH{1'b0}}, b_q};
  assign p_su = {{WIDTH{a_q[WIDTH-1]}}, a_q} * {{WIDTH{1'b0}}, b_q};
  assign p_ss = {{WIDTH{a_q[WIDTH-1]}}, a_q} * {{WIDTH{b_q[WIDTH-1]}}, b_q};
  assign lat_exp = LAT_W'(WIDTH + 1) + ((m_q == 2'b10) ? LAT_W'(1) :
                                        (m_q == 2'b11) ? LAT_W'(2) : LAT_W'(0));

  always_ff @(posedge clk) begin
    was_rst_q <= rst;
    if (rst) begin
      track_q <= 1'b0;
      lat_q   <= '0;
      a_q     <= '0;
      b_q     <= '0;
      m_q     <= '0;
    end else if (acc) begin
      track_q <= 1'b1;
      lat_q   <= LAT_W'(1);
      a_q     <= in_mcand;
      b_q     <= in_mplr;
      m_q     <= in_mode;
    end else if (done) begin
      track_q <= 1'b0;
    end else if (track_q) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && was_rst_q === 1'b1)
      assert_reset_state_R8: assert (in_ready && !done && result == '0);
  end

  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (rst)
    acc |=> !in_ready);
  assert_busy_at_done_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);
  assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> (track_q && lat_q == lat_exp));
  assert_low_half_R3: assert property (@(posedge clk) disable iff (rst)
    (done && m_q == 2'b00) |-> result == p_uu[WIDTH-1:0]);
  assert_high_uu_R4: assert property (@(posedge clk) disable iff (rst)
    (done && m_q == 2'b01) |-> result == p_uu[W2-1:WIDTH]);
  assert_high_su_R5: assert property (@(posedge clk) disable iff (rst)
    (done && m_q == 2'b10) |-> result == p_su[W2-1:WIDTH]);
  assert_high_ss_R6: assert property (@(posedge clk) disable iff (rst)
    (done && m_q == 2'b11) |-> result == p_ss[W2-1:WIDTH]);
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_quiet_result_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> result == '0);
  assert_one_done_per_accept_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> track_q);
endmodule

bind shiftadd_mul shiftadd_mul_chk #(.WIDTH(WIDTH)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_mcand(in_mcand),
  .in_mplr (in_mplr),
  .in_mode (in_mode),
  .done    (done),
  .result  (result)
);

// File: tb/shiftadd_mul_tb_top.sv
module shiftadd_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH      = 32;

  typedef struct {
    logic [31:0] exp;
    logic [1:0]  mode;
    int          acc;
    logic [31:0] a;
    logic [31:0] b;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_mcand = '0, in_mplr = '0;
  logic [1:0]  in_mode = '0;
  logic        in_ready, done;
  logic [31:0] result;

  int    checks = 0, fails = 0, cyc = 0, pushed = 0, popped = 0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  shiftadd_mul #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mcand(in_mcand), .in_mplr(in_mplr), .in_mode(in_mode),
    .done(done), .result(result)
  );

  function automatic string req_of(input logic [1:0] m);
    case (m)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                         input logic [1:0] m);
    logic [63:0] ua, ub, sa, sb2, p;
    ua = {32'b0, a}; ub = {32'b0, b};
    sa = {{32{a[31]}}, a}; sb2 = {{32{b[31]}}, b};
    case (m)
      2'b00: begin p = ua * ub;  return p[31:0];  end
      2'b01: begin p = ua * ub;  return p[63:32]; end
      2'b10: begin p = sa * ub;  return p[63:32]; end
      default: begin p = sa * sb2; return p[63:32]; end
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: waits for ready, presents one request, records expectation
  task automatic send(input logic [31:0] a, input logic [31:0] b, input logic [1:0] m);
    item_t it;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_mcand = a; in_mplr = b; in_mode = m;
    it.exp = model(a, b, m); it.mode = m; it.acc = cyc + 1; it.a = a; it.b = b;
    sb.push_back(it);
    pushed++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: pops and compares result and latency (R2)
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb.size() == 0) begin
          check(1'b0, "R9", result, 32'h0);
        end else begin
          item_t it;
          int lat, want;
          it = sb.pop_front();
          popped++;
          check(result == it.exp, req_of(it.mode), result, it.exp);
          lat  = cyc - it.acc;
          want = WIDTH + ((it.mode == 2'b10) ? 1 : (it.mode == 2'b11) ? 2 : 0);
          check(lat == want, "R2", 32'(lat), 32'(want));
        end
      end
    end
  end

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  logic [31:0] corners [5];
  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001; corners[2] = 32'hFFFF_FFFF;
    corners[3] = 32'h7FFF_FFFF; corners[4] = 32'h8000_0000;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: reset state
    check(in_ready == 1'b1, "R8", {31'b0, in_ready}, 32'h1);
    check(done == 1'b0, "R8", {31'b0, done}, 32'h0);
    check(result == 32'h0, "R8", result, 32'h0);

    // R3..R6: corner pairs in every mode
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          send(corners[i], corners[j], 2'(m));

    // R3: low half equal across modes' sign interpretations (random operands)
    for (int k = 0; k < 40; k++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      for (int m = 0; m < 4; m++) send(a, b, 2'(m));
    end

    // R1/R9: requests presented while busy are ignored
    send(32'h1234_5678, 32'h9ABC_DEF0, 2'b11);
    for (int n = 0; n < 10; n++) begin
      in_valid = 1'b1; in_mcand = 32'hDEAD_BEEF; in_mplr = 32'h0BAD_F00D; in_mode = 2'b01;
      check(in_ready == 1'b0, "R1", {31'b0, in_ready}, 32'h0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    send(32'hFFFF_FFFE, 32'h0000_0003, 2'b10);

    while (sb.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    // R7: single-cycle done pulse, quiet result when idle
    check(done == 1'b0 && result == 32'h0, "R7", result, 32'h0);
    // R9: one done per accepted request, nothing extra
    check(popped == pushed, "R9", 32'(popped), 32'(pushed));
    summary();
    $finish;
  end
endmodule